// File: doc/BRIEF.md
# Paged Framebuffer Pixel Scanner

The scanner turns a byte-organised graphics memory into a raster stream of one-bit pixels for a small display window. The memory is split into eight pages. Each page holds 132 column bytes, and each byte carries eight vertically stacked pixels. The scanner walks a visible window of 96 columns by 16 rows. That window begins at column 36 of every page. The first visible row comes from a programmable 6-bit start line, and the row index wraps modulo 64.

Every source pixel is magnified by four in both directions, so a frame is 384 by 64 output pixels, delivered one per clock with valid, end-of-line and end-of-frame markers. Two polarity controls shape the output. The all-on control forces every pixel lit. The inverse control swaps lit and unlit. A frame is scanned only after a redraw request. A request that arrives while a frame is in flight is held, and it yields exactly one more frame.

Memory is read through a synchronous port with one cycle of latency. The scanner's internal pipeline keeps each pixel aligned with its markers.

Top module: `fb_pixel_scanner`

## Requirements
- R1: A frame consists of exactly 24576 pixels (384 per line, 64 lines) with `pixValid` high on every cycle from the first pixel to the end-of-frame pixel, without gaps.
- R2: For output line y, the source line is (y/4 + start line) mod 64; the page is source line bits [5:3] and the pixel is bit (source line mod 8) of the byte, bit 0 being the top line of a page.
- R3: For output column x, the byte read is at address 132*page + 36 + x/4, and `memAddr` never leaves the range 0..1055 while `memRdEn` is high.
- R4: Each source pixel appears on 4 consecutive output columns, and each source line appears on 4 consecutive output lines.
- R5: With `allOn` low and `inverse` low, a set memory bit gives `pixData`=1 and a clear bit gives 0.
- R6: With `allOn` low and `inverse` high, a set memory bit gives `pixData`=0 and a clear bit gives 1.
- R7: With `allOn` high, `pixData` is 1 for every pixel regardless of memory and of `inverse`.
- R8: `pixEol` is high exactly on output column 383 of each line; `pixEof` is high exactly on column 383 of line 63; both only with `pixValid`.
- R9: Without a redraw request no pixel is produced (`pixValid` stays low).
- R10: Redraw requests made during a frame, one or many, cause exactly one further frame after the current one ends.
- R11: The start line is captured when a frame begins; changes to `startLine` during a frame affect only later frames.
- R12: During and right after reset, `pixValid`, `pixEol`, `pixEof` and `memRdEn` are low and no redraw is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redrawReq | input | 1 | Single-cycle request for a frame |
| startLine | input | 6 | Source line shown on the first output row |
| inverse | input | 1 | Swap lit and unlit pixels |
| allOn | input | 1 | Force every pixel lit |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | 11 | Memory byte address |
| memData | input | 8 | Memory read data, valid one cycle after the read |
| pixValid | output | 1 | Output pixel valid |
| pixData | output | 1 | Output pixel, 1 = lit |
| pixEol | output | 1 | Last pixel of an output line |
| pixEof | output | 1 | Last pixel of the frame |

## Verification
Checked every cycle: the markers only appear with a valid pixel, and end-of-frame only appears with end-of-line. A frame runs without gaps, and addresses stay inside the memory. An address does not change across the four repeats of one source pixel. The captured start line holds for a whole frame, and a frame starts only when a redraw is pending. Only the bench scenarios show the rest. Those are the pixel values against a model of random memory with a wrapping start line, the three polarity modes, the exact marker positions, and the way several requests made during a frame collapse into one further frame.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam int BYTE_BITS = 8;
  localparam int BIT_IDX_W = 3;

  typedef struct packed {
    logic                 valid;
    logic                 eol;
    logic                 eof;
    logic [BIT_IDX_W-1:0] bitSel;
  } scanStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_e;
endpackage

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
  import fb_scan_pkg::*;
#(
  parameter int VIS_COLS   = 96,
  parameter int VIS_ROWS   = 16,
  parameter int MAG        = 4,
  parameter int PAGE_BYTES = 132,
  parameter int COL_OFS    = 36,
  parameter int LINE_BITS  = 6,
  localparam int PAGES     = (1 << LINE_BITS) / BYTE_BITS,
  localparam int MEM_DEPTH = PAGES * PAGE_BYTES,
  localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 redrawReq,
  input  logic [LINE_BITS-1:0] startLine,
  output logic                 memRdEn,
  output logic [ADDR_W-1:0]    memAddr,
  output scanStrobe_t          strobe
);
  localparam int SUB_W  = (MAG > 1) ? $clog2(MAG) : 1;
  localparam int COL_W  = $clog2(VIS_COLS);
  localparam int PAGE_W = LINE_BITS - BIT_IDX_W;

  scanState_e           state;
  logic                 pending;
  logic [LINE_BITS-1:0] slLat;
  logic [SUB_W-1:0]     subX, subY;
  logic [COL_W-1:0]     srcX;
  logic [LINE_BITS-1:0] srcY;

  logic                 startFrame, lastX, lastY, scanning;
  logic [LINE_BITS-1:0] srcLine;
  logic [PAGE_W-1:0]    page;

  assign scanning   = (state == ST_SCAN);
  assign startFrame = (state == ST_IDLE) && pending;
  assign lastX      = (subX == SUB_W'(MAG - 1)) && (srcX == COL_W'(VIS_COLS - 1));
  assign lastY      = (subY == SUB_W'(MAG - 1)) && (srcY == LINE_BITS'(VIS_ROWS - 1));
  assign srcLine    = srcY + slLat;
  assign page       = srcLine[LINE_BITS-1:BIT_IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      slLat   <= '0;
      subX    <= '0;
      subY    <= '0;
      srcX    <= '0;
      srcY    <= '0;
    end else begin
      pending <= redrawReq | (pending & ~startFrame);
      if (startFrame) begin
        state <= ST_SCAN;
        slLat <= startLine;
        subX  <= '0;
        subY  <= '0;
        srcX  <= '0;
        srcY  <= '0;
      end else if (scanning) begin
        if (subX != SUB_W'(MAG - 1)) begin
          subX <= subX + 1'b1;
        end else begin
          subX <= '0;
          if (srcX != COL_W'(VIS_COLS - 1)) begin
            srcX <= srcX + 1'b1;
          end else begin
            srcX <= '0;
            if (subY != SUB_W'(MAG - 1)) begin
              subY <= subY + 1'b1;
            end else begin
              subY <= '0;
              if (srcY != LINE_BITS'(VIS_ROWS - 1)) srcY <= srcY + 1'b1;
              else                                  srcY <= '0;
            end
          end
        end
        if (lastX && lastY) state <= ST_IDLE;
      end
    end
  end

  assign memRdEn = scanning;
  assign memAddr = ADDR_W'(page) * ADDR_W'(PAGE_BYTES) + ADDR_W'(COL_OFS) + ADDR_W'(srcX);

  always_comb begin
    strobe        = '0;
    strobe.valid  = scanning;
    strobe.eol    = scanning && lastX;
    strobe.eof    = scanning && lastX && lastY;
    strobe.bitSel = srcLine[BIT_IDX_W-1:0];
  end

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr < ADDR_W'(MEM_DEPTH)));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && subX != '0) |-> $stable(memAddr));

  assert_start_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && $past(scanning)) |-> $stable(slLat));

  assert_start_needs_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scanning) |-> $past(pending));
endmodule

// File: rtl/fb_scan_datapath.sv
module fb_scan_datapath
  import fb_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  input  logic [BYTE_BITS-1:0] memData,
  input  logic                 inverse,
  input  logic                 allOn,
  output logic                 pixValid,
  output logic                 pixData,
  output logic                 pixEol,
  output logic                 pixEof
);
  scanStrobe_t stage1;
  logic        rawBit;

  assign rawBit = memData[stage1.bitSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1   <= '0;
      pixValid <= 1'b0;
      pixData  <= 1'b0;
      pixEol   <= 1'b0;
      pixEof   <= 1'b0;
    end else begin
      stage1   <= strobe;
      pixValid <= stage1.valid;
      pixData  <= stage1.valid & (allOn | (rawBit ^ inverse));
      pixEol   <= stage1.eol;
      pixEof   <= stage1.eof;
    end
  end

  assert_eof_on_eol_R8: assert property (@(posedge clk) disable iff (!rstN)
    pixEof |-> pixEol);

  assert_marker_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixEol || pixEof) |-> pixValid);

  assert_no_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixEof) |=> pixValid);
endmodule

// File: rtl/fb_pixel_scanner.sv
module fb_pixel_scanner
  import fb_scan_pkg::*;
#(
  parameter int VIS_COLS   = 96,
  parameter int VIS_ROWS   = 16,
  parameter int MAG        = 4,
  parameter int PAGE_BYTES = 132,
  parameter int COL_OFS    = 36,
  parameter int LINE_BITS  = 6,
  localparam int ADDR_W    = $clog2(((1 << LINE_BITS) / BYTE_BITS) * PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 redrawReq,
  input  logic [LINE_BITS-1:0] startLine,
  input  logic                 inverse,
  input  logic                 allOn,
  output logic                 memRdEn,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic [BYTE_BITS-1:0] memData,
  output logic                 pixValid,
  output logic                 pixData,
  output logic                 pixEol,
  output logic                 pixEof
);
  scanStrobe_t strobe;

  fb_scan_ctrl #(
    .VIS_COLS(VIS_COLS), .VIS_ROWS(VIS_ROWS), .MAG(MAG),
    .PAGE_BYTES(PAGE_BYTES), .COL_OFS(COL_OFS), .LINE_BITS(LINE_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .redrawReq(redrawReq), .startLine(startLine),
    .memRdEn(memRdEn), .memAddr(memAddr), .strobe(strobe)
  );

  fb_scan_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memData(memData),
    .inverse(inverse), .allOn(allOn),
    .pixValid(pixValid), .pixData(pixData), .pixEol(pixEol), .pixEof(pixEof)
  );
endmodule

// File: tb/tb_fb_pixel_scanner.sv
module tb_fb_pixel_scanner;
  localparam int MEM_DEPTH = 1056;
  localparam int FRAME_PIX = 384 * 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic redrawReq = 1'b0;
  logic [5:0] startLine = '0;
  logic inverse = 1'b0, allOn = 1'b0;
  logic memRdEn;
  logic [10:0] memAddr;
  logic [7:0] memData = '0;
  logic pixValid, pixData, pixEol, pixEof;

  always #5 clk = ~clk;

  fb_pixel_scanner dut (
    .clk(clk), .rstN(rstN), .redrawReq(redrawReq), .startLine(startLine),
    .inverse(inverse), .allOn(allOn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memData(memData), .pixValid(pixValid), .pixData(pixData),
    .pixEol(pixEol), .pixEof(pixEof)
  );

  logic [7:0] mem [MEM_DEPTH];
  always @(posedge clk) if (memRdEn) memData <= mem[memAddr];

  int checks = 0, errors = 0;
  int framesDone = 0, validSeen = 0;
  int bx = 0, by = 0, pixCnt = 0, dataErr = 0, markErr = 0, gapErr = 0;
  int firstAct = 0, firstExp = 0;
  logic inFrame = 1'b0;
  logic [5:0] frameSl [8];
  logic frameInv [8], frameOn [8];
  string frameTag [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expPix(int x, int y, logic [5:0] sl, logic inv, logic on);
    int line, addr;
    line = ((y / 4) + int'(sl)) % 64;
    addr = 132 * (line >> 3) + 36 + (x / 4);
    if (on) return 1'b1;
    return mem[addr][line % 8] ^ inv;
  endfunction

  always @(negedge clk) begin
    if (pixValid) begin
      logic e;
      int fi;
      fi = framesDone % 8;
      validSeen++;
      inFrame = 1'b1;
      e = expPix(bx, by, frameSl[fi], frameInv[fi], frameOn[fi]);
      if (pixData !== e) begin
        if (dataErr == 0) begin firstAct = int'(pixData); firstExp = int'(e); end
        dataErr++;
      end
      if (pixEol !== (bx == 383) || pixEof !== (bx == 383 && by == 63)) markErr++;
      pixCnt++;
      if (bx == 383) begin bx = 0; by++; end else bx++;
      if (pixEof) begin
        check(dataErr == 0, {frameTag[fi], " pixel value"}, firstAct, firstExp);
        check(markErr == 0, "R8 marker position errors", markErr, 0);
        check(pixCnt == FRAME_PIX && gapErr == 0, "R1 pixel count per frame", pixCnt, FRAME_PIX);
        framesDone++;
        bx = 0; by = 0; pixCnt = 0; dataErr = 0; markErr = 0; gapErr = 0;
        inFrame = 1'b0;
      end
    end else if (inFrame) begin
      gapErr++;
    end
  end

  task automatic fillMem();
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = 8'($urandom);
  endtask

  task automatic pulseReq();
    @(negedge clk); redrawReq = 1'b1;
    @(negedge clk); redrawReq = 1'b0;
  endtask

  task automatic setFrame(int idx, logic [5:0] sl, logic inv, logic on, string tag);
    frameSl[idx] = sl; frameInv[idx] = inv; frameOn[idx] = on; frameTag[idx] = tag;
  endtask

  task automatic waitFrames(int n);
    while (framesDone < n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired frames=%0d expected=5", framesDone);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    fillMem();
    repeat (3) @(negedge clk);
    check(!pixValid && !pixEol && !pixEof && !memRdEn, "R12 outputs low in reset",
          int'({pixValid, pixEol, pixEof, memRdEn}), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (200) @(negedge clk);
    check(validSeen == 0 && !memRdEn, "R12 R9 no frame without request", validSeen, 0);

    // Frame 0: plain polarity, start line 0
    setFrame(0, 6'd0, 1'b0, 1'b0, "R2 R3 R4 R5");
    startLine = 6'd0; inverse = 1'b0; allOn = 1'b0;
    pulseReq();
    waitFrames(1);
    repeat (20) @(negedge clk);
    check(framesDone == 1 && !pixValid, "R9 single frame per request", framesDone, 1);

    // Frame 1: wrapped start line, inverse
    fillMem();
    setFrame(1, 6'd61, 1'b1, 1'b0, "R2 R6 wrap");
    startLine = 6'd61; inverse = 1'b1;
    pulseReq();
    waitFrames(2);

    // Frame 2: all-on overrides inverse and memory
    setFrame(2, 6'd17, 1'b1, 1'b1, "R7");
    startLine = 6'd17; allOn = 1'b1;
    pulseReq();
    waitFrames(3);
    @(negedge clk); allOn = 1'b0; inverse = 1'b0;

    // Frames 3 and 4: requests during a scan, start line changed mid-frame
    fillMem();
    setFrame(3, 6'd9, 1'b0, 1'b0, "R11 R5 captured start");
    setFrame(4, 6'd52, 1'b0, 1'b0, "R10 R11 follow-on");
    startLine = 6'd9;
    pulseReq();
    repeat (100) @(negedge clk);
    startLine = 6'd52;
    pulseReq();
    repeat (300) @(negedge clk);
    pulseReq();
    pulseReq();
    waitFrames(4);
    check(framesDone == 4, "R10 first frame of pair done", framesDone, 4);
    waitFrames(5);
    repeat (400) @(negedge clk);
    check(framesDone == 5 && !pixValid && !memRdEn, "R10 exactly one extra frame",
          framesDone, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule